// File: doc/BRIEF.md
# Regulator Soft-Start Sequencer and Fault Supervisor

This block is the digital supervisor of a synchronous step-down converter. It runs on the switching clock and sees the analog world only through comparator flags. Once the bias supply is out of lockout, enable is high and the feedback pin checks out, it counts switching cycles through a soft-start ramp. It marks the point where the output is in regulation, releases full synchronous rectification near the end of the ramp, and arms fault handling when the ramp completes.

Five fault sources are qualified separately: feedback undervoltage, feedback overvoltage, current limit, a shorted high-side switch and over-temperature. Each source has its own count of consecutive cycles and its own rule about whether it is honoured during the ramp. When a fault qualifies, the supervisor stops switching and latches. It then discharges the output through the low-side switch with hysteresis, so the output does not swing negative. Power-good is reported only after arming, and only while feedback is inside its window. The latch is cleared by dropping enable or losing bias. A sticky cause register keeps the first fault seen since reset.

Top module: `buck_supervisor`

## Requirements
- R1: Switching (`switch_en`=1) starts one clock after `bias_ok`, `en` and `fb_sane` are all high together, and the ramp count starts from zero. With any of the three low, `switch_en` stays 0.
- R2: `in_reg` rises REG_CYCLES (3200) clocks after the first ramp cycle. `armed` rises ARM_CYCLES (4000) clocks after it.
- R3: `sync_en` rises at 95% of REG_CYCLES (3040 clocks) into the ramp.
- R4: `fb_low` sets the latch after 16 consecutive clocks, and only while armed. During the ramp it is ignored.
- R5: `fb_high` sets the latch after 2 consecutive clocks, during the ramp as well as after arming.
- R6: `ilim_hit` sets the latch after 16 consecutive clocks, during the ramp as well as after arming.
- R7: `hs_short` or `over_temp` sets the latch at the first clock it is seen.
- R8: When the latch sets, `ls_discharge` goes to 1. It drops to 0 when `fb_below_dis` is seen, and returns to 1 only when `fb_above_rel` is seen.
- R9: `pgood` equals `fb_in_window` while armed and unlatched. At all other times it is 0, including during the ramp.
- R10: `en` low or `bias_ok` low returns the block to idle within one clock, clears the latch and stops switching. A later start begins the ramp from zero.
- R11: A cycle without its condition resets a source's consecutive count to zero.
- R12: `fault_cause` holds the qualifying sources of the first latch since reset, encoded as bit0 undervoltage, bit1 overvoltage, bit2 current limit, bit3 high-side short, bit4 over-temperature. It survives restarts and is cleared only by `rst_n`.
- R13: `switch_en` is 0 while idle or latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Active-low reset |
| bias_ok | input | 1 | Bias supply above lockout |
| en | input | 1 | Enable pin high |
| fb_sane | input | 1 | Feedback pin neither open nor shorted |
| fb_low | input | 1 | Feedback below the undervoltage threshold |
| fb_high | input | 1 | Feedback above the overvoltage threshold |
| ilim_hit | input | 1 | Current limit hit this cycle |
| hs_short | input | 1 | High-side switch short detected |
| over_temp | input | 1 | Die over temperature |
| fb_below_dis | input | 1 | Feedback below the discharge stop level |
| fb_above_rel | input | 1 | Feedback above the discharge resume level |
| fb_in_window | input | 1 | Feedback inside the power-good window |
| switch_en | output | 1 | Modulator allowed to switch |
| in_reg | output | 1 | Ramp has reached the regulation point |
| sync_en | output | 1 | Full synchronous rectification allowed |
| armed | output | 1 | Ramp complete, latch armed |
| fault_latched | output | 1 | Fault latch set |
| ls_discharge | output | 1 | Drive the low-side switch for discharge |
| pgood | output | 1 | Power-good |
| fault_cause | output | 5 | Sticky first-fault causes |

## Verification
The undervoltage path is the hardest to reach. It counts only after a full 4000-cycle ramp, and its 16-cycle qualification must be told apart from a 15-cycle run and from a run broken by one clean cycle. Each table row therefore resets the block, steps through the whole ramp to the armed state, and then holds one fault flag for an exact number of cycles. Directed runs follow. They drive undervoltage and current-limit flags during the ramp, break a run with a single gap, walk the discharge hysteresis, and restart through enable while watching that the cause register keeps the first fault.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_RUN  = 2'd2,
    ST_TRIP = 2'd3
  } seq_state_t;

  localparam int NSRC      = 5;
  localparam int SRC_UV    = 0;
  localparam int SRC_OV    = 1;
  localparam int SRC_OC    = 2;
  localparam int SRC_SHORT = 3;
  localparam int SRC_HOT   = 4;

  // integer percentage of a cycle count
  function automatic int unsigned pct_of(int unsigned v, int unsigned pct);
    return (v * pct) / 100;
  endfunction

  // a source trips on the qual-th consecutive cycle of its condition
  function automatic logic qual_hit(logic cond, logic run,
                                    int unsigned cnt, int unsigned qual);
    return run && cond && (cnt == qual - 1);
  endfunction

endpackage

// File: rtl/bsup_qualifier.sv
module bsup_qualifier
  import bsup_pkg::*;
#(
  parameter int unsigned QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cond,
  output logic trip
);

  localparam int unsigned CW = (QUAL < 2) ? 1 : $clog2(QUAL);

  logic [CW-1:0] run_cnt;

  assign trip = qual_hit(cond, run, 32'(run_cnt), QUAL);

  always_ff @(posedge clk) begin
    if (!rst_n)                   run_cnt <= '0;
    else if (run && cond && !trip) run_cnt <= run_cnt + 1'b1;
    else                          run_cnt <= '0;
  end

  generate
    if (QUAL >= 2) begin : g_chk
      // R11: a qualified trip needs the condition in the previous cycle too
      a_r11_trip_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(run && cond));
    end
  endgenerate

endmodule

// File: rtl/bsup_sequencer.sv
module bsup_sequencer
  import bsup_pkg::*;
#(
  parameter int unsigned ARM_CYCLES = 4000,
  parameter int unsigned CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bias_ok,
  input  logic             en,
  input  logic             fb_sane,
  input  logic             fault_set,
  output seq_state_t       state,
  output logic [CNT_W-1:0] ramp_cnt
);

  logic go, stop;
  assign go   = bias_ok && en && fb_sane;
  assign stop = !bias_ok || !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ramp_cnt <= '0;
    end else if (stop) begin
      state    <= ST_IDLE;
      ramp_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          state    <= ST_RAMP;
          ramp_cnt <= '0;
        end
        ST_RAMP: begin
          if (fault_set) state <= ST_TRIP;
          else begin
            ramp_cnt <= ramp_cnt + 1'b1;
            if (ramp_cnt == CNT_W'(ARM_CYCLES - 1)) state <= ST_RUN;
          end
        end
        ST_RUN:  if (fault_set) state <= ST_TRIP;
        default: state <= ST_TRIP;
      endcase
    end
  end

  // R10: dropping enable returns to idle on the next edge
  a_r10_en_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state == ST_IDLE);

  // R2: the armed state is only reached from the last ramp count
  a_r2_arm_after_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> ($past(state) == ST_RUN ||
                           $past(ramp_cnt) == CNT_W'(ARM_CYCLES - 1)));

endmodule

// File: rtl/bsup_discharge.sv
module bsup_discharge (
  input  logic clk,
  input  logic rst_n,
  input  logic entering,
  input  logic latched,
  input  logic fb_below_dis,
  input  logic fb_above_rel,
  output logic ls_on
);

  always_ff @(posedge clk) begin
    if (!rst_n)                         ls_on <= 1'b0;
    else if (entering)                  ls_on <= 1'b1;
    else if (!latched)                  ls_on <= 1'b0;
    else if (ls_on && fb_below_dis)     ls_on <= 1'b0;
    else if (!ls_on && fb_above_rel)    ls_on <= 1'b1;
  end

  // R8: while latched, the low side comes back only above the resume level
  a_r8_rearm_hyst: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_on) && $past(latched)) |-> $past(fb_above_rel));

endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
  import bsup_pkg::*;
#(
  parameter int unsigned REG_CYCLES = 3200,
  parameter int unsigned ARM_CYCLES = 4000,
  parameter int unsigned SYNC_PCT   = 95,
  parameter int unsigned UV_QUAL    = 16,
  parameter int unsigned OV_QUAL    = 2,
  parameter int unsigned OC_QUAL    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bias_ok,
  input  logic       en,
  input  logic       fb_sane,
  input  logic       fb_low,
  input  logic       fb_high,
  input  logic       ilim_hit,
  input  logic       hs_short,
  input  logic       over_temp,
  input  logic       fb_below_dis,
  input  logic       fb_above_rel,
  input  logic       fb_in_window,
  output logic       switch_en,
  output logic       in_reg,
  output logic       sync_en,
  output logic       armed,
  output logic       fault_latched,
  output logic       ls_discharge,
  output logic       pgood,
  output logic [4:0] fault_cause
);

  localparam int unsigned SYNC_CYCLES = pct_of(REG_CYCLES, SYNC_PCT);
  localparam int unsigned CNT_W       = $clog2(ARM_CYCLES + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  ramp_cnt;
  logic              active, ramping;
  logic [NSRC-1:0]   src_cond, src_run, src_trip;
  logic              fault_set;

  assign active  = (state == ST_RAMP) || (state == ST_RUN);
  assign ramping = (state == ST_RAMP);

  assign src_cond = {over_temp, hs_short, ilim_hit, fb_high, fb_low};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam int unsigned Q = (i == SRC_UV) ? UV_QUAL :
                                  (i == SRC_OV) ? OV_QUAL :
                                  (i == SRC_OC) ? OC_QUAL : 1;
      assign src_run[i] = (i == SRC_UV) ? (state == ST_RUN) : active;
      bsup_qualifier #(.QUAL(Q)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (src_run[i]),
        .cond  (src_cond[i]),
        .trip  (src_trip[i])
      );
    end
  endgenerate

  assign fault_set = (|src_trip) && bias_ok && en;

  bsup_sequencer #(.ARM_CYCLES(ARM_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bias_ok   (bias_ok),
    .en        (en),
    .fb_sane   (fb_sane),
    .fault_set (fault_set),
    .state     (state),
    .ramp_cnt  (ramp_cnt)
  );

  bsup_discharge u_dis (
    .clk          (clk),
    .rst_n        (rst_n),
    .entering     (fault_set),
    .latched      (state == ST_TRIP),
    .fb_below_dis (fb_below_dis),
    .fb_above_rel (fb_above_rel),
    .ls_on        (ls_discharge)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                            fault_cause <= '0;
    else if (fault_set && fault_cause == '0) fault_cause <= src_trip;
  end

  assign switch_en     = active;
  assign armed         = (state == ST_RUN);
  assign fault_latched = (state == ST_TRIP);
  assign in_reg        = armed || (ramping && ramp_cnt >= CNT_W'(REG_CYCLES));
  assign sync_en       = armed || (ramping && ramp_cnt >= CNT_W'(SYNC_CYCLES));
  assign pgood         = armed && fb_in_window;

  // R12: a latch event always leaves a recorded cause behind
  a_r12_cause_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> fault_cause != '0);

  // R13: latching only happens from a switching state
  a_r13_latch_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(switch_en));

endmodule

// File: tb/buck_supervisor_test.sv
module buck_supervisor_test;

  localparam int PERIOD = 10;
  localparam int ARM = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_ok = 1'b0, en = 1'b0, fb_sane = 1'b0;
  logic fb_low = 1'b0, fb_high = 1'b0, ilim_hit = 1'b0, hs_short = 1'b0, over_temp = 1'b0;
  logic fb_below_dis = 1'b0, fb_above_rel = 1'b0, fb_in_window = 1'b0;
  logic switch_en, in_reg, sync_en, armed, fault_latched, ls_discharge, pgood;
  logic [4:0] fault_cause;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  buck_supervisor uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // rows: {source[3:0], hold cycles[7:0], expect latch[3:0]}
  localparam logic [15:0] VEC [8] = '{
    {4'd1, 8'd1,  4'd0}, {4'd1, 8'd2,  4'd1},
    {4'd2, 8'd15, 4'd0}, {4'd2, 8'd16, 4'd1},
    {4'd0, 8'd15, 4'd0}, {4'd0, 8'd16, 4'd1},
    {4'd3, 8'd1,  4'd1}, {4'd4, 8'd1,  4'd1}
  };

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_src(input int src, input logic v);
    case (src)
      0: fb_low = v;
      1: fb_high = v;
      2: ilim_hit = v;
      3: hs_short = v;
      default: over_temp = v;
    endcase
  endtask

  task automatic clear_faults();
    fb_low = 0; fb_high = 0; ilim_hit = 0; hs_short = 0; over_temp = 0;
  endtask

  // reset, then leave it on the first ramp cycle (count zero)
  task automatic start_ramp();
    clear_faults();
    bias_ok = 1; en = 1; fb_sane = 1;
    rst_n = 0; step(2); rst_n = 1;
    step(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state
    step(3);
    check("R13 reset switch_en", switch_en, 0);
    check("R12 reset cause", fault_cause, 0);
    check("R9 reset pgood", pgood, 0);
    rst_n = 1;

    // R1: start conditions
    bias_ok = 1; en = 1; fb_sane = 0; step(5);
    check("R1 no start without fb_sane", switch_en, 0);
    fb_sane = 1; bias_ok = 0; step(5);
    check("R1 no start without bias", switch_en, 0);
    bias_ok = 1; step(1);
    check("R1 start", switch_en, 1);
    check("R3 sync low at count 0", sync_en, 0);

    // R2, R3, R9 timing along the ramp
    fb_in_window = 1;
    step(3039); check("R3 sync at 3039", sync_en, 0);
    step(1);    check("R3 sync at 3040", sync_en, 1);
    step(159);  check("R2 in_reg at 3199", in_reg, 0);
    step(1);    check("R2 in_reg at 3200", in_reg, 1);
    check("R9 pgood low in ramp", pgood, 0);
    step(799);  check("R2 armed at 3999", armed, 0);
    step(1);    check("R2 armed at 4000", armed, 1);
    check("R9 pgood high armed in window", pgood, 1);
    fb_in_window = 0; #1;
    check("R9 pgood low out of window", pgood, 0);

    // table: per-source qualification after arming (R4 R5 R6 R7 R12)
    for (int r = 0; r < 8; r++) begin
      int src, hold, ex;
      src = int'(VEC[r][15:12]); hold = int'(VEC[r][11:4]); ex = int'(VEC[r][3:0]);
      start_ramp(); step(ARM);
      set_src(src, 1); step(hold); set_src(src, 0);
      check($sformatf("R4-7 row%0d src%0d latch", r, src), fault_latched, ex);
      check($sformatf("R12 row%0d cause", r), fault_cause, ex ? (32'd1 << src) : 0);
    end

    // R4: undervoltage ignored during the ramp
    start_ramp(); fb_low = 1; step(100); fb_low = 0;
    check("R4 uv ignored in ramp", fault_latched, 0);

    // R5: overvoltage honoured during the ramp
    start_ramp(); step(10); fb_high = 1; step(2); fb_high = 0;
    check("R5 ov in ramp", fault_latched, 1);
    check("R5 ov cause", fault_cause, 5'b00010);

    // R6: current limit honoured during the ramp
    start_ramp(); step(10); ilim_hit = 1; step(15);
    check("R6 oc 15 in ramp", fault_latched, 0);
    step(1); ilim_hit = 0;
    check("R6 oc 16 in ramp", fault_latched, 1);

    // R11: a gap restarts the count
    start_ramp(); step(ARM);
    fb_low = 1; step(15); fb_low = 0; step(1); fb_low = 1; step(15);
    check("R11 gap resets count", fault_latched, 0);
    step(1); fb_low = 0;
    check("R11 16 after gap", fault_latched, 1);

    // R8 discharge hysteresis, R13 no switching while latched
    check("R8 discharge on entry", ls_discharge, 1);
    check("R13 no switching latched", switch_en, 0);
    fb_below_dis = 1; step(1); fb_below_dis = 0;
    check("R8 stop below level", ls_discharge, 0);
    step(3);
    check("R8 stays off", ls_discharge, 0);
    fb_above_rel = 1; step(1); fb_above_rel = 0;
    check("R8 resume above level", ls_discharge, 1);

    // R10 restart by enable, R12 cause kept
    en = 0; step(1);
    check("R10 latch cleared", fault_latched, 0);
    check("R10 idle no switching", switch_en, 0);
    check("R12 cause kept over restart", fault_cause, 5'b00001);
    en = 1; step(1);
    check("R10 restart", switch_en, 1);
    step(3039);
    check("R10 ramp from zero", sync_en, 0);
    hs_short = 1; step(1); hs_short = 0;
    check("R7 short latch", fault_latched, 1);
    check("R12 first cause held", fault_cause, 5'b00001);
    bias_ok = 0; step(1);
    check("R10 bias loss clears", fault_latched, 0);
    rst_n = 0; step(1);
    check("R12 cause cleared by reset", fault_cause, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule